// File: doc/BRIEF.md
# Master-Slave PWM Output Controller

This block produces a pulse-width modulated waveform on a single output pin from two down-counters that advance on a shared count-clock strobe. The master counter defines the period: each time it sits at zero on a count tick, it reloads the period value and emits a one-cycle interrupt pulse. The slave counter reloads the duty value on that same master event and flags the end of the active phase when it counts out. An output stage turns the master event, delayed by one count tick, into a set condition and the slave expiry into a reset condition. A reset always beats a coincident set, which makes 0% and 100% duty produce clean constant levels.

The pin polarity is programmable. A polarity change is not applied to the pin directly: the pin keeps its level until the next set or reset condition, and only then takes the level implied by the new polarity. An output enable can freeze the pin. Clearing the run bit, or withholding the count strobe, freezes both counters and the pin. Everything is clocked by one system clock and has a synchronous active-high reset.

Top module: `pwm_ms_ctrl`

## Requirements
- R1: While `rst_i` is high, and in the first cycle after it falls, `pwm_o` equals the inverse of `act_lvl_i`, which is the inactive level (`act_lvl_i` = 1 means active-high, 0 means active-low), and `mst_irq_o` is 0.
- R2: A count tick is a cycle with `run_i` and `cnt_en_i` both high. The first tick after reset is a master event, and further master events follow every `period_i`+1 ticks. `mst_irq_o` is high for exactly the one cycle after each master-event tick.
- R3: The set condition belongs to the tick that follows a master event. With duty nonzero, `pwm_o` goes to the active level in the cycle after that tick.
- R4: When 0 < `duty_i` <= `period_i`, the pin is active for exactly `duty_i` ticks per period. The reset condition falls on the tick whose phase index, counted from 0 at the set tick, equals `duty_i`.
- R5: When a set and a reset condition fall on the same tick, the reset wins. As a result, `duty_i` = 0 holds the pin at the inactive level.
- R6: When `duty_i` > `period_i`, the slave never expires before its reload, so the pin stays active. When `duty_i` = `period_i`, the pin is inactive for exactly one tick per period.
- R7: Changing `act_lvl_i` leaves `pwm_o` unchanged until the next set or reset condition. At that condition the pin takes the active or inactive level under the new polarity.
- R8: While `out_en_i` is low, `pwm_o` holds its level and both set and reset conditions are dropped. The counters keep running.
- R9: In a cycle that is not a count tick, neither counter moves, `pwm_o` holds its level and `mst_irq_o` stays 0. Counting then resumes from where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cnt_en_i | input | 1 | Count-clock strobe, one system cycle per count |
| run_i | input | 1 | Run bit; counters advance only while high |
| period_i | input | W | Master reload value; period is period_i+1 ticks |
| duty_i | input | W | Slave reload value; active length in ticks |
| act_lvl_i | input | 1 | Active level of the pin (1 = high) |
| out_en_i | input | 1 | Output enable; low freezes the pin |
| pwm_o | output | 1 | Registered PWM output pin |
| mst_irq_o | output | 1 | Registered master period interrupt pulse |

## Verification
Both outputs are registers, so each result of a count tick appears in the system cycle right after the tick's rising edge. The bench drives a one-cycle strobe at a falling edge and samples `pwm_o` and `mst_irq_o` at the next falling edge, which is half a cycle after that tick's edge. Expected levels come from a tick-indexed event model: a set falls where (tick-1) mod (period+1) is 0, and a reset falls where that phase equals the duty. Idle cycles between ticks are sampled the same way, and there both outputs must show no change.

// File: rtl/pwm_ms_pkg.sv
package pwm_ms_pkg;

  typedef struct packed {
    logic set;
    logic clr;
  } pin_evt_t;

  // Level the pin takes for a pair of conditions; reset dominates set.
  function automatic logic resolve_pin(input pin_evt_t ev, input logic act_lvl);
    return (ev.set && !ev.clr) ? act_lvl : !act_lvl;
  endfunction

endpackage

// File: rtl/pwm_master_cnt.sv
module pwm_master_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic [W-1:0] period_i,
  output logic         evt_o,
  output logic         irq_o
);
  logic [W-1:0] cnt_q;
  logic         at_zero;

  assign at_zero = (cnt_q == '0);
  assign evt_o   = tick_i && at_zero;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      irq_o <= 1'b0;
    end else begin
      irq_o <= evt_o;
      if (tick_i) begin
        cnt_q <= at_zero ? period_i : cnt_q - W'(1);
      end
    end
  end
endmodule

// File: rtl/pwm_slave_cnt.sv
module pwm_slave_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] duty_i,
  output logic         clr_o
);
  logic [W-1:0] cnt_q;
  logic         arm_q;

  // Expiry is tested on the old count, so it may share a tick with a reload.
  assign clr_o = tick_i && arm_q && (cnt_q == '0);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (tick_i) begin
      if (load_i) begin
        cnt_q <= duty_i;
        arm_q <= 1'b1;
      end else if (arm_q) begin
        if (cnt_q == '0) begin
          arm_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_ms_pkg::*;
(
  input  logic clk_i,
  input  logic rst_i,
  input  logic tick_i,
  input  logic mst_evt_i,
  input  logic clr_i,
  input  logic act_lvl_i,
  input  logic out_en_i,
  output logic set_o,
  output logic pin_o
);
  logic     set_dly_q;
  pin_evt_t ev;

  assign set_o  = tick_i && set_dly_q;
  assign ev.set = set_o;
  assign ev.clr = clr_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      set_dly_q <= 1'b0;
      pin_o     <= !act_lvl_i;
    end else begin
      if (tick_i) begin
        set_dly_q <= mst_evt_i;
      end
      if (out_en_i && (ev.set || ev.clr)) begin
        pin_o <= resolve_pin(ev, act_lvl_i);
      end
    end
  end
endmodule

// File: rtl/pwm_ms_ctrl.sv
module pwm_ms_ctrl #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cnt_en_i,
  input  logic         run_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  logic         act_lvl_i,
  input  logic         out_en_i,
  output logic         pwm_o,
  output logic         mst_irq_o
);
  logic tick;
  logic mst_evt;
  logic set_evt;
  logic clr_evt;

  assign tick = run_i && cnt_en_i;

  pwm_master_cnt #(.W(W)) u_master (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .tick_i   (tick),
    .period_i (period_i),
    .evt_o    (mst_evt),
    .irq_o    (mst_irq_o)
  );

  pwm_slave_cnt #(.W(W)) u_slave (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .tick_i (tick),
    .load_i (mst_evt),
    .duty_i (duty_i),
    .clr_o  (clr_evt)
  );

  pwm_out_stage u_out (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .tick_i    (tick),
    .mst_evt_i (mst_evt),
    .clr_i     (clr_evt),
    .act_lvl_i (act_lvl_i),
    .out_en_i  (out_en_i),
    .set_o     (set_evt),
    .pin_o     (pwm_o)
  );
endmodule

// File: rtl/pwm_ms_ctrl_chk.sv
module pwm_ms_ctrl_chk (
  input logic clk_i,
  input logic rst_i,
  input logic cnt_en_i,
  input logic run_i,
  input logic act_lvl_i,
  input logic out_en_i,
  input logic pwm_o,
  input logic mst_irq_o,
  input logic set_evt,
  input logic clr_evt
);
  p_rst_inactive_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    $past(rst_i) |-> (pwm_o == !$past(act_lvl_i)) && !mst_irq_o);

  p_irq_follows_tick_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    mst_irq_o |-> $past(run_i && cnt_en_i));

  p_reset_wins_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && $past(set_evt && clr_evt && out_en_i) |-> pwm_o == !$past(act_lvl_i));

  p_hold_disabled_r8: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(out_en_i) |-> $stable(pwm_o));

  p_hold_no_tick_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !$past(rst_i) && !$past(run_i && cnt_en_i) |-> $stable(pwm_o) && !mst_irq_o);
endmodule

bind pwm_ms_ctrl pwm_ms_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_i     (rst_i),
  .cnt_en_i  (cnt_en_i),
  .run_i     (run_i),
  .act_lvl_i (act_lvl_i),
  .out_en_i  (out_en_i),
  .pwm_o     (pwm_o),
  .mst_irq_o (mst_irq_o),
  .set_evt   (set_evt),
  .clr_evt   (clr_evt)
);

// File: tb/pwm_ms_ctrl_tb_top.sv
module pwm_ms_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 3;
  localparam int TMAX = (1 << TW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cnt_en = 1'b0;
  logic          run = 1'b0;
  logic [TW-1:0] period = '0;
  logic [TW-1:0] duty = '0;
  logic          act_lvl = 1'b1;
  logic          out_en = 1'b1;
  logic          pwm;
  logic          irq;

  int  n_chk = 0;
  int  n_fail = 0;
  int  P = 0;
  int  D = 0;
  int  tcnt = 0;
  bit  mdl_pin = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_ms_ctrl #(.W(TW)) dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .cnt_en_i  (cnt_en),
    .run_i     (run),
    .period_i  (period),
    .duty_i    (duty),
    .act_lvl_i (act_lvl),
    .out_en_i  (out_en),
    .pwm_o     (pwm),
    .mst_irq_o (irq)
  );

  task automatic chk(input string tag, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s P=%0d D=%0d tick=%0d got=%b exp=%b", tag, P, D, tcnt, got, exp);
    end
  endtask

  task automatic do_reset(input int p, input int d);
    P = p; D = d;
    period = TW'(p); duty = TW'(d);
    rst = 1'b1; run = 1'b0; cnt_en = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    tcnt = 0;
    mdl_pin = !act_lvl;
    @(negedge clk);
    chk("R1 pin", pwm, !act_lvl);
    chk("R1 irq", irq, 1'b0);
    run = 1'b1;
  endtask

  // One count tick; the outputs are sampled at the next falling edge.
  task automatic tick_chk(input string tag);
    bit s, c;
    int ph;
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
    s = 1'b0; c = 1'b0;
    if (tcnt >= 1) begin
      ph = (tcnt - 1) % (P + 1);
      s = (ph == 0);
      c = (D <= P) && (ph == D);
    end
    if (out_en && (s || c)) mdl_pin = (s && !c) ? act_lvl : !act_lvl;
    chk(tag, pwm, mdl_pin);
    chk("R2 irq", irq, (tcnt % (P + 1)) == 0);
    tcnt++;
  endtask

  task automatic idle_chk(input int n, input bit drop_run);
    if (drop_run) begin
      run = 1'b0; cnt_en = 1'b1;
    end else begin
      cnt_en = 1'b0;
    end
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R9 pin held", pwm, mdl_pin);
      chk("R9 no irq", irq, 1'b0);
    end
    run = 1'b1; cnt_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    // Sweep every period/duty pair of the small configuration (R4, R5, R6).
    for (int p = 0; p <= TMAX; p++) begin
      for (int d = 0; d <= TMAX; d++) begin
        act_lvl = ((p + d) % 2) == 0;
        out_en = 1'b1;
        do_reset(p, d);
        for (int t = 0; t < 2 * (p + 1) + 3; t++) begin
          if (d == 0) tick_chk("R5 zero duty");
          else if (d > p) tick_chk("R6 full duty");
          else tick_chk("R4 duty");
          if (((t + p + d) % 5) == 0) idle_chk(1, (d % 2) == 1);
        end
      end
    end

    // R3: set lands one tick after the master event.
    act_lvl = 1'b1; out_en = 1'b1;
    do_reset(3, 2);
    tick_chk("R3 master tick");
    chk("R3 not yet active", pwm, 1'b0);
    tick_chk("R3 delayed set");
    chk("R3 active", pwm, 1'b1);

    // R7: polarity change waits for the next condition.
    tick_chk("R7 pre");
    act_lvl = 1'b0;
    @(negedge clk);
    chk("R7 no immediate change", pwm, 1'b1);
    tick_chk("R7 reset new polarity");
    tick_chk("R7 idle tick");
    tick_chk("R7 set new polarity");
    chk("R7 active low", pwm, 1'b0);
    tick_chk("R7 hold");
    tick_chk("R7 reset");

    // R8: disabled output ignores set and reset.
    act_lvl = 1'b1;
    do_reset(3, 2);
    for (int i = 0; i < 4; i++) tick_chk("R8 pre");
    out_en = 1'b0;
    for (int i = 0; i < 5; i++) tick_chk("R8 disabled");
    chk("R8 frozen", pwm, 1'b0);
    out_en = 1'b1;
    for (int i = 0; i < 6; i++) tick_chk("R8 reenabled");

    // R9: run cleared and strobe withheld mid-active.
    do_reset(4, 3);
    tick_chk("R9 pre");
    tick_chk("R9 pre");
    idle_chk(6, 1'b1);
    idle_chk(4, 1'b0);
    for (int i = 0; i < 8; i++) tick_chk("R9 resume");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule